// File: doc/BRIEF.md
# Parallel Camera Pixel Bus Generator

This block drives an 8-bit parallel video stream the way the output port of an image sensor does. Each frame is marked by a frame-valid qualifier and each row of active pixels by a line-valid qualifier. Frame width, frame height, the idle gap between rows and the idle gap between frames are configuration inputs. The block counts rows and pixels internally. While line-valid is high it places a deterministic test pattern on the data bus, so the receiving capture logic can be exercised without a real sensor.

Frame-valid always opens a fixed guard of six clocks before the first row of a frame. It also stays high for six clocks after the last row ends. The configuration is captured only when a frame starts, so a frame always finishes with the geometry it started with. The outputs can be launched from the rising edge of the pixel clock, or re-registered and launched from the falling edge. In both cases the receiver samples on the opposite edge. Dropping the enable input lets the current frame finish, including its inter-frame gap, and then holds the qualifiers low.

Top module: `pixbus_gen`

## Requirements
- R1: A rising clock edge that samples `rst_n` low drives `frame_valid`, `line_valid` and `pix_data` to 0 right after that edge, whatever launch edge was in use, and selects rising-edge launch.
- R2: In every frame, `frame_valid` rises exactly 6 clocks before the first rise of `line_valid`.
- R3: In every frame, `frame_valid` falls exactly 6 clocks after the last fall of `line_valid`.
- R4: A frame contains exactly `cfg_height` pulses of `line_valid`. Each pulse is high for exactly `cfg_width` clocks. Consecutive pulses are separated by exactly `cfg_hblank` clocks with `line_valid` low and `frame_valid` high.
- R5: While `line_valid` is high, `pix_data` equals (row index + pixel index) mod 256, with both indices counted from 0 within the frame. While `line_valid` is low, `pix_data` is 0.
- R6: With `enable` held high, `frame_valid` stays low for exactly `cfg_vblank` clocks between two consecutive frames.
- R7: When idle, a rising edge that samples `enable` high starts a frame. In rising-launch mode, `frame_valid` goes high at the next rising edge.
- R8: If `enable` falls during a frame, that frame still completes in full, and afterwards `frame_valid` and `line_valid` stay low for as long as `enable` stays low.
- R9: The geometry inputs and `cfg_fall_launch` are captured at the edge that starts a frame. Changing them while a frame is in progress has no effect on that frame's outputs.
- R10: With `cfg_fall_launch` = 0, the outputs change only on rising clock edges. With `cfg_fall_launch` = 1, they change only on falling edges, carrying the rising-launch stream delayed by half a clock.
- R11: `line_valid` is never high while `frame_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Start frames while high; when low, stop after the current frame |
| cfg_width | input | DIM_W | Active pixels per row (at least 1) |
| cfg_height | input | DIM_W | Active rows per frame (at least 1) |
| cfg_hblank | input | DIM_W | Clocks between rows inside a frame (at least 1) |
| cfg_vblank | input | DIM_W | Clocks with frame-valid low between frames (at least 1) |
| cfg_fall_launch | input | 1 | 1 launches outputs from the falling edge, 0 from the rising edge |
| pix_data | output | 8 | Pixel data bus |
| frame_valid | output | 1 | Frame qualifier |
| line_valid | output | 1 | Row qualifier |

## Verification
Some properties are checked by assertions on every cycle:
- the 6-clock guard at both ends of a frame,
- the number of rows per frame,
- pixel indices staying inside the row,
- zero data outside rows,
- line-valid only inside frame-valid,
- the captured geometry staying frozen while a frame runs,
- the falling-edge stage following the rising-edge stage.

Other behaviour can only be shown by the bench's scenarios, because it depends on how stimulus is ordered:
- that configuration changes in mid-frame take effect only at the next frame,
- that a frame cut short by enable still completes,
- that the inter-frame gap matches its setting,
- that in falling mode no output change ever falls on a rising edge,
- that a mid-frame reset clears the outputs while falling launch is active.

// File: rtl/pixbus_pkg.sv
`timescale 1ns/1ps
// Package pixbus_pkg
// Shared types for the parallel pixel bus generator: the frame sequencer
// state and the per-clock output beat (qualifiers plus data byte).
package pixbus_pkg;

    localparam int PIX_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for enable
        ST_LEAD = 3'd1,   // frame-valid high, guard before first row
        ST_LINE = 3'd2,   // row active
        ST_HGAP = 3'd3,   // gap between rows
        ST_TAIL = 3'd4,   // frame-valid high, guard after last row
        ST_VGAP = 3'd5    // gap between frames
    } scan_state_t;

    typedef struct packed {
        logic             fv;
        logic             lv;
        logic [PIX_W-1:0] data;
    } pix_beat_t;

endpackage

// File: rtl/pixbus_cfg_latch.sv
`timescale 1ns/1ps
// Module pixbus_cfg_latch
// Holds the frame geometry and launch-edge choice used by the running frame.
// It loads the live inputs only on the cycle the sequencer starts a frame.
// Assumes: capture is asserted only while frame-valid is low.
module pixbus_cfg_latch #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             frame_busy,
    input  logic [DIM_W-1:0] in_width,
    input  logic [DIM_W-1:0] in_height,
    input  logic [DIM_W-1:0] in_hblank,
    input  logic [DIM_W-1:0] in_vblank,
    input  logic             in_fall,
    output logic [DIM_W-1:0] width_q,
    output logic [DIM_W-1:0] height_q,
    output logic [DIM_W-1:0] hblank_q,
    output logic [DIM_W-1:0] vblank_q,
    output logic             fall_q
);

    localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

    // Capture the live configuration at frame start; reset to minimal legal geometry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= ONE;
            height_q <= ONE;
            hblank_q <= ONE;
            vblank_q <= ONE;
            fall_q   <= 1'b0;
        end else if (capture) begin
            width_q  <= in_width;
            height_q <= in_height;
            hblank_q <= in_hblank;
            vblank_q <= in_vblank;
            fall_q   <= in_fall;
        end
    end

    // R9: settings stay frozen while a frame runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && $past(frame_busy)) |->
            ($stable(width_q) && $stable(height_q) && $stable(hblank_q) && $stable(fall_q)));

endmodule

// File: rtl/pixbus_scan.sv
`timescale 1ns/1ps
// Module pixbus_scan
// Frame sequencer: walks guard, rows, row gaps, trailing guard and frame gap
// with one down-counter, tracks row and pixel indices, and forms the
// unregistered output beat (qualifiers and test pattern) on the rising edge.
// Assumes: geometry inputs are the latched values, each at least 1.
module pixbus_scan
    import pixbus_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int GUARD = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIM_W-1:0] act_w,
    input  logic [DIM_W-1:0] act_h,
    input  logic [DIM_W-1:0] gap_h,
    input  logic [DIM_W-1:0] gap_v,
    output logic             capture,
    output pix_beat_t        beat
);

    localparam int GW = $clog2(GUARD + 1);
    localparam int CW = (DIM_W > GW) ? DIM_W : GW;
    localparam logic [CW-1:0] GUARD_LD = CW'(GUARD - 1);
    localparam logic [CW-1:0] C_ONE    = CW'(1);
    localparam logic [DIM_W-1:0] D_ONE = DIM_W'(1);

    scan_state_t      st_q;
    logic [CW-1:0]    cnt_q;
    logic [DIM_W-1:0] pix_q;
    logic [DIM_W-1:0] line_q;
    logic             cnt_done;
    logic             last_line;
    logic [CW-1:0]    w_ld;
    logic [CW-1:0]    hg_ld;
    logic [CW-1:0]    vg_ld;
    logic [PIX_W-1:0] pattern;

    assign cnt_done  = (cnt_q == '0);
    assign last_line = (line_q == (act_h - D_ONE));
    assign w_ld      = CW'(act_w) - C_ONE;
    assign hg_ld     = CW'(gap_h) - C_ONE;
    assign vg_ld     = CW'(gap_v) - C_ONE;
    assign capture   = enable && ((st_q == ST_IDLE) || ((st_q == ST_VGAP) && cnt_done));

    // Advance the frame state machine and its interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pix_q  <= '0;
            line_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (enable) begin
                        st_q   <= ST_LEAD;
                        cnt_q  <= GUARD_LD;
                        line_q <= '0;
                    end
                end
                ST_LEAD: begin
                    if (cnt_done) begin
                        st_q  <= ST_LINE;
                        cnt_q <= w_ld;
                        pix_q <= '0;
                    end else begin
                        cnt_q <= cnt_q - C_ONE;
                    end
                end
                ST_LINE: begin
                    pix_q <= pix_q + D_ONE;
                    if (cnt_done) begin
                        if (last_line) begin
                            st_q  <= ST_TAIL;
                            cnt_q <= GUARD_LD;
                        end else begin
                            st_q  <= ST_HGAP;
                            cnt_q <= hg_ld;
                        end
                    end else begin
                        cnt_q <= cnt_q - C_ONE;
                    end
                end
                ST_HGAP: begin
                    if (cnt_done) begin
                        st_q   <= ST_LINE;
                        cnt_q  <= w_ld;
                        pix_q  <= '0;
                        line_q <= line_q + D_ONE;
                    end else begin
                        cnt_q <= cnt_q - C_ONE;
                    end
                end
                ST_TAIL: begin
                    if (cnt_done) begin
                        st_q  <= ST_VGAP;
                        cnt_q <= vg_ld;
                    end else begin
                        cnt_q <= cnt_q - C_ONE;
                    end
                end
                ST_VGAP: begin
                    if (cnt_done) begin
                        if (enable) begin
                            st_q   <= ST_LEAD;
                            cnt_q  <= GUARD_LD;
                            line_q <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - C_ONE;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Test pattern: row index plus pixel index, truncated to the bus width.
    generate
        if (DIM_W + 1 >= PIX_W) begin : g_sum_wide
            logic [DIM_W:0] sum;
            assign sum     = {1'b0, line_q} + {1'b0, pix_q};
            assign pattern = sum[PIX_W-1:0];
        end else begin : g_sum_narrow
            logic [PIX_W-1:0] sum;
            assign sum     = PIX_W'(line_q) + PIX_W'(pix_q);
            assign pattern = sum;
        end
    endgenerate

    // Decode qualifiers from state and blank the data outside rows.
    always_comb begin
        beat.fv   = (st_q == ST_LEAD) || (st_q == ST_LINE) ||
                    (st_q == ST_HGAP) || (st_q == ST_TAIL);
        beat.lv   = (st_q == ST_LINE);
        beat.data = beat.lv ? pattern : '0;
    end

    // Observation counters for the guard and row-count properties.
    logic [GW:0]      lead_q;
    logic [GW:0]      tail_q;
    logic [DIM_W-1:0] rows_q;
    logic             seen_lv_q;
    logic             lv_d_q;
    localparam logic [GW:0] G_CAP = (GW + 1)'(GUARD + 1);

    // Count clocks since frame-valid rose and since the last row ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q    <= '0;
            tail_q    <= '0;
            rows_q    <= '0;
            seen_lv_q <= 1'b0;
            lv_d_q    <= 1'b0;
        end else begin
            lv_d_q <= beat.lv;
            if (!beat.fv)              lead_q <= '0;
            else if (lead_q != G_CAP)  lead_q <= lead_q + 1'b1;
            if (!beat.fv || beat.lv)   tail_q <= '0;
            else if (tail_q != G_CAP)  tail_q <= tail_q + 1'b1;
            if (!beat.fv)              seen_lv_q <= 1'b0;
            else if (beat.lv)          seen_lv_q <= 1'b1;
            if (!beat.fv)                   rows_q <= '0;
            else if (beat.lv && !lv_d_q)    rows_q <= rows_q + D_ONE;
        end
    end

    // R2: guard from frame start to the first row
    p_lead_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(beat.lv) && !seen_lv_q) |-> (lead_q == (GW + 1)'(GUARD)));

    // R3: guard from the last row to frame end
    p_tail_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beat.fv) |-> (tail_q == (GW + 1)'(GUARD)));

    // R4: row count per frame matches the captured height
    p_row_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beat.fv) |-> (rows_q == act_h));

    // R5: pixel index stays inside the captured row width
    p_pix_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat.lv |-> (pix_q < act_w));

endmodule

// File: rtl/pixbus_launch.sv
`timescale 1ns/1ps
// Module pixbus_launch
// Output register stage. A rising-edge register always holds the beat; a
// second register re-captures it on the falling edge. The captured launch
// choice selects which of the two drives the pins.
// Assumes: fall_sel changes only while both registers hold idle values.
module pixbus_launch
    import pixbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_sel,
    input  pix_beat_t        beat_in,
    output logic             fv_o,
    output logic             lv_o,
    output logic [PIX_W-1:0] data_o
);

    pix_beat_t rise_q;
    pix_beat_t fall_q;
    pix_beat_t pick;

    // Rising-edge launch register.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= beat_in;
    end

    // Falling-edge re-register of the rising-edge stage.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= rise_q;
    end

    // Choose the launch edge that drives the pins.
    always_comb begin
        pick   = fall_sel ? fall_q : rise_q;
        fv_o   = pick.fv;
        lv_o   = pick.lv;
        data_o = pick.data;
    end

    // R11: row qualifier only inside the frame qualifier
    p_lv_inside_fv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q.lv |-> rise_q.fv);

    // R5: data bus is zero outside rows
    p_blank_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_q.lv |-> (rise_q.data == '0));

    // R10: falling stage carries the rising stage half a clock later
    p_fall_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fall_q == rise_q));

endmodule

// File: rtl/pixbus_gen.sv
`timescale 1ns/1ps
// Module pixbus_gen
// Top of the parallel camera pixel bus generator: configuration capture,
// frame sequencer and launch-edge output stage.
// Assumes: all geometry inputs are at least 1; outputs are sampled by the
// receiver on the edge opposite to the selected launch edge.
module pixbus_gen
    import pixbus_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int GUARD = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic [DIM_W-1:0] cfg_hblank,
    input  logic [DIM_W-1:0] cfg_vblank,
    input  logic             cfg_fall_launch,
    output logic [7:0]       pix_data,
    output logic             frame_valid,
    output logic             line_valid
);

    logic             capture;
    logic [DIM_W-1:0] width_q;
    logic [DIM_W-1:0] height_q;
    logic [DIM_W-1:0] hblank_q;
    logic [DIM_W-1:0] vblank_q;
    logic             fall_q;
    pix_beat_t        beat;

    pixbus_cfg_latch #(.DIM_W(DIM_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .frame_busy (beat.fv),
        .in_width   (cfg_width),
        .in_height  (cfg_height),
        .in_hblank  (cfg_hblank),
        .in_vblank  (cfg_vblank),
        .in_fall    (cfg_fall_launch),
        .width_q    (width_q),
        .height_q   (height_q),
        .hblank_q   (hblank_q),
        .vblank_q   (vblank_q),
        .fall_q     (fall_q)
    );

    pixbus_scan #(.DIM_W(DIM_W), .GUARD(GUARD)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .act_w   (width_q),
        .act_h   (height_q),
        .gap_h   (hblank_q),
        .gap_v   (vblank_q),
        .capture (capture),
        .beat    (beat)
    );

    pixbus_launch u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_sel (fall_q),
        .beat_in  (beat),
        .fv_o     (frame_valid),
        .lv_o     (line_valid),
        .data_o   (pix_data)
    );

endmodule

// File: tb/sim_pixbus_gen.sv
`timescale 1ns/1ps
// Bench for pixbus_gen: behavioural frame model built from queues, compared
// against the pins on every clock, plus qualifier-timing monitors.
module sim_pixbus_gen;

    localparam int DW = 12;
    localparam int G  = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [DW-1:0] c_w, c_h, c_hb, c_vb;
    logic          c_fall;
    logic [7:0]    pix_data;
    logic          frame_valid, line_valid;

    always #2.5 clk = ~clk;

    pixbus_gen #(.DIM_W(DW), .GUARD(G)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(en),
        .cfg_width(c_w), .cfg_height(c_h), .cfg_hblank(c_hb), .cfg_vblank(c_vb),
        .cfg_fall_launch(c_fall),
        .pix_data(pix_data), .frame_valid(frame_valid), .line_valid(line_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { int w; int h; int hb; int vb; bit b2b; } geom_t;
    logic [9:0] mq[$];
    geom_t      gq[$];
    logic [9:0] pend, exp_r, exp_prev;
    bit         sel_m, last_idle;

    task automatic push_frame(input int w, input int h, input int hb, input int vb);
        for (int i = 0; i < G; i++) mq.push_back(10'h200);
        for (int l = 0; l < h; l++) begin
            for (int p = 0; p < w; p++) mq.push_back({2'b11, 8'((l + p) % 256)});
            if (l < h - 1) for (int i = 0; i < hb; i++) mq.push_back(10'h200);
        end
        for (int i = 0; i < G; i++) mq.push_back(10'h200);
        for (int i = 0; i < vb; i++) mq.push_back(10'h000);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); gq.delete();
            pend = 0; exp_r = 0; exp_prev = 0; sel_m = 0; last_idle = 1;
        end else begin
            exp_prev = exp_r;
            exp_r    = pend;
            if (mq.size() == 0) begin
                if (en) begin
                    geom_t g;
                    g.w = int'(c_w); g.h = int'(c_h); g.hb = int'(c_hb); g.vb = int'(c_vb);
                    g.b2b = !last_idle;
                    gq.push_back(g);
                    push_frame(g.w, g.h, g.hb, g.vb);
                    sel_m = c_fall;
                    last_idle = 0;
                end else begin
                    mq.push_back(10'h000);
                    last_idle = 1;
                end
            end
            pend = mq.pop_front();
        end
    end

    // ---------------- per-clock compare and monitors ----------------
    bit    pfv, plv, first_row;
    int    since_fv, tail, rows, pw, gap_h, gap_v, prev_vb;
    int    frames_done, last_rows, last_w;
    geom_t cur;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            pfv = 0; plv = 0; since_fv = 0; tail = 0; rows = 0; pw = 0;
            gap_h = 0; gap_v = 0; prev_vb = 0;
        end else begin
            logic [9:0] e;
            e = sel_m ? exp_prev : exp_r;
            chk({frame_valid, line_valid, pix_data} === e, "R5 stream (R4 R7 R10)",
                int'({frame_valid, line_valid, pix_data}), int'(e));
            if (line_valid && !frame_valid) chk(0, "R11", 1, 0);
            // frame start
            if (frame_valid && !pfv) begin
                if (gq.size() == 0) chk(0, "R7 unexpected frame", 1, 0);
                else begin
                    cur = gq.pop_front();
                    if (cur.b2b) chk(gap_v == prev_vb, "R6 vblank", gap_v, prev_vb);
                end
                since_fv = 0; rows = 0; first_row = 1;
            end else since_fv++;
            if (!frame_valid) gap_v = pfv ? 1 : gap_v + 1;
            // rows
            if (line_valid && !plv) begin
                if (first_row) chk(since_fv == G, "R2 lead guard", since_fv, G);
                else chk(gap_h == cur.hb, "R4 hblank", gap_h, cur.hb);
                first_row = 0; rows++; pw = 1;
            end else if (line_valid) pw++;
            if (!line_valid && plv) begin
                chk(pw == cur.w, "R4 width", pw, cur.w);
                last_w = pw; tail = 0; gap_h = 1;
            end else if (!line_valid) begin
                tail++; gap_h++;
            end
            // frame end
            if (!frame_valid && pfv) begin
                chk(tail == G, "R3 trail guard", tail, G);
                chk(rows == cur.h, "R4 rows", rows, cur.h);
                prev_vb = cur.vb; last_rows = rows; frames_done++;
            end
            pfv = frame_valid; plv = line_valid;
        end
    end

    // launch-edge watcher
    int n_rise_chg, n_fall_chg;
    always @(frame_valid, line_valid, pix_data) begin
        if (clk) n_rise_chg++; else n_fall_chg++;
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (mq.size() == 0 && pend == 0 && exp_r == 0 && exp_prev == 0 && !frame_valid) break;
            cyc(1);
        end
        cyc(2);
    endtask

    task automatic set_cfg(input int w, input int h, input int hb, input int vb, input bit f);
        c_w = DW'(w); c_h = DW'(h); c_hb = DW'(hb); c_vb = DW'(vb); c_fall = f;
    endtask

    initial begin
        int fd;
        rst_n = 0; en = 0;
        set_cfg(5, 3, 2, 4, 0);
        cyc(4);
        // R1 reset state
        chk(frame_valid == 0 && line_valid == 0 && pix_data == 0, "R1 reset",
            int'({frame_valid, line_valid, pix_data}), 0);
        rst_n = 1;
        cyc(3);
        chk(frame_valid == 0, "R8 idle without enable", frame_valid, 0);

        // R7: start latency, rising launch
        en = 1;
        @(posedge clk); #1;
        chk(frame_valid == 0, "R7 not yet", frame_valid, 0);
        @(posedge clk); #1;
        chk(frame_valid == 1, "R7 frame start", frame_valid, 1);
        #1;
        n_rise_chg = 0; n_fall_chg = 0;
        cyc(100);                                   // about three back-to-back frames (R6)
        en = 0;
        wait_idle();
        chk(n_fall_chg == 0, "R10 rising launch", n_fall_chg, 0);
        chk(n_rise_chg > 0, "R10 rising activity", n_rise_chg, 1);

        // corner geometry: all ones
        set_cfg(1, 1, 1, 1, 0);
        en = 1; cyc(60); en = 0; wait_idle();
        chk(last_rows == 1 && last_w == 1, "R4 minimal frame", last_rows * 10 + last_w, 11);

        // pattern wrap past 255
        set_cfg(300, 2, 3, 2, 0);
        en = 1; cyc(20); en = 0; wait_idle();
        chk(last_w == 300, "R5 wide row", last_w, 300);

        // falling-edge launch
        set_cfg(6, 4, 3, 3, 1);
        n_rise_chg = 0; n_fall_chg = 0;
        en = 1; cyc(150); en = 0; wait_idle();
        chk(n_rise_chg == 0, "R10 falling launch", n_rise_chg, 0);
        chk(n_fall_chg > 0, "R10 falling activity", n_fall_chg, 1);

        // R9: change config mid-frame
        set_cfg(4, 2, 3, 2, 0);
        fd = frames_done;
        en = 1; cyc(12);
        set_cfg(7, 3, 1, 5, 0);
        for (int i = 0; i < 500 && frames_done == fd; i++) cyc(1);
        chk(last_rows == 2, "R9 rows of running frame", last_rows, 2);
        chk(last_w == 4, "R9 width of running frame", last_w, 4);
        for (int i = 0; i < 500 && frames_done == fd + 1; i++) cyc(1);
        chk(last_rows == 3 && last_w == 7, "R9 next frame uses new cfg",
            last_rows * 10 + last_w, 37);
        en = 0; wait_idle();

        // R8: disable mid-frame, frame completes, then stays low
        set_cfg(5, 4, 2, 3, 0);
        fd = frames_done;
        en = 1; cyc(20); en = 0;
        wait_idle();
        chk(frames_done == fd + 1, "R8 frame completed", frames_done - fd, 1);
        begin
            int hi = 0;
            for (int i = 0; i < 100; i++) begin cyc(1); if (frame_valid || line_valid) hi++; end
            chk(hi == 0, "R8 held low", hi, 0);
        end

        // R1: reset mid-frame while falling launch active
        set_cfg(8, 3, 2, 2, 1);
        en = 1; cyc(30);
        chk(frame_valid == 1, "R1 frame running before reset", frame_valid, 1);
        rst_n = 0;
        cyc(1);
        chk(frame_valid == 0 && line_valid == 0 && pix_data == 0, "R1 reset mid-frame",
            int'({frame_valid, line_valid, pix_data}), 0);
        en = 0; cyc(2); rst_n = 1;
        cyc(10);
        chk(frame_valid == 0, "R1 idle after reset", frame_valid, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule